// File: doc/BRIEF.md
# Verified Serial Gamepad Poller

This block polls serial 8-bit gamepads on several ports and protects each result against a single corrupted read. A frame begins with a one-cycle `start` pulse. The block then works through the ports strictly one after another. For each port it pulses that port's latch line and clocks eight button bits in. It reads the port again. If the two reads differ, it reads a third time.

A port's value is accepted as soon as two reads agree. If all three reads differ, the value accepted in an earlier frame stays on the output and that port's valid bit is cleared.

Every sampled bit is the OR of the port's main data line and its expansion data line. A cycle counter measures how long each port's verification takes. It raises `overrun` when that time reaches the budget within which at most one corrupting event can occur. When the last port has been decided, the block pulses `done` for one cycle.

Top module: `gp_poller`

## Requirements
- R1: After reset, all latch and clock lines are low, every `pad_value` byte and every `valid` bit is 0, and `done` and `overrun` are 0.
- R2: Each read raises exactly one port's latch for STB_CYC cycles. After the latch falls, that port's clock pulses high exactly 8 times. Latch and clock are never high together. The first latch of a frame rises two cycles after `start` is taken.
- R3: Bits are sampled before each clock pulse and assembled LSB-first: the bit present right after the latch falls lands in bit 0. Each sampled bit is main data OR expansion data.
- R4: If the first two reads of a port agree, that byte is accepted, valid is set, and no third read is made (2 latch pulses).
- R5: If the first two reads differ, a third read is made. The byte is accepted with valid set if the third read equals either of the first two.
- R6: If no two of the three reads agree, the port's `pad_value` keeps its previous content and its valid bit is 0.
- R7: A port is fully verified before any latch or clock activity on the next port. Ports are served in ascending index order.
- R8: `done` is high for exactly one cycle per frame, after the last port is decided. `pad_value` and `valid` change only while a frame is in progress.
- R9: `overrun` is cleared when a frame starts. It is set if, for any port, the cycles from that port's first read launch to its final read completing reach BUDGET.
- R10: A `start` pulse during a frame is ignored: it causes no extra reads and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling all ports |
| pad_data | input | PORTS | Main serial data per port |
| pad_exp | input | PORTS | Expansion serial data per port, OR-ed with main |
| pad_latch | output | PORTS | Latch (strobe) line per port |
| pad_clk | output | PORTS | Shift clock per port |
| pad_value | output | PORTS x BITS | Accepted button byte per port |
| valid | output | PORTS | Port's reads agreed this frame |
| done | output | 1 | One-cycle frame-complete pulse |
| overrun | output | 1 | A port's verification reached the cycle budget |

## Verification
A pad model presents its own byte on each latch, so the bench can choose the agreement pattern per port:
- All three reads equal. This separates the two-read early exit from the third read.
- First and third reads equal. This checks the fallback comparison with the first read.
- Second and third reads equal. This checks the fallback comparison with the second read.
- All three reads different. This checks that the previous value is kept.

Asymmetric bytes such as 0x01 against 0x80 show whether the bit order is reversed. A nonzero expansion byte shows whether the two data lines are OR-ed. A second instance with a slow shift clock crosses the cycle budget, while the default instance stays below it. Random frames then mix all four patterns with carried-over history.

// File: rtl/gp_pkg.sv
package gp_pkg;
  typedef enum logic [2:0] {
    E_IDLE,
    E_LATCH,
    E_SAMP,
    E_HIGH,
    E_LOW
  } eng_state_t;

  typedef enum logic [1:0] {
    T_IDLE,
    T_RUN,
    T_DONE
  } top_state_t;
endpackage

// File: rtl/gp_read_engine.sv
module gp_read_engine
  import gp_pkg::*;
#(
  parameter int BITS     = 8,
  parameter int STB_CYC  = 2,
  parameter int HALF_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            din,
  output logic            latch,
  output logic            sclk,
  output logic            busy,
  output logic            fin,
  output logic [BITS-1:0] rd_byte
);
  localparam int TMAX = (STB_CYC > HALF_CYC) ? STB_CYC : HALF_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int BW   = $clog2(BITS);

  eng_state_t      st;
  logic [TW-1:0]   tmr;
  logic [BW-1:0]   bitn;
  logic [BITS-1:0] sr;

  assign latch   = (st == E_LATCH);
  assign sclk    = (st == E_HIGH);
  assign busy    = (st != E_IDLE);
  assign rd_byte = sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= E_IDLE;
      tmr  <= '0;
      bitn <= '0;
      sr   <= '0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        E_IDLE: if (go) begin
          st  <= E_LATCH;
          tmr <= TW'(STB_CYC - 1);
        end
        E_LATCH: if (tmr == '0) st <= E_SAMP;
                 else tmr <= tmr - 1'b1;
        E_SAMP: begin
          sr  <= {din, sr[BITS-1:1]};
          st  <= E_HIGH;
          tmr <= TW'(HALF_CYC - 1);
        end
        E_HIGH: if (tmr == '0) begin
          st  <= E_LOW;
          tmr <= TW'(HALF_CYC - 1);
        end else tmr <= tmr - 1'b1;
        E_LOW: if (tmr == '0) begin
          if (bitn == BW'(BITS - 1)) begin
            st   <= E_IDLE;
            bitn <= '0;
            fin  <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
            st   <= E_SAMP;
          end
        end else tmr <= tmr - 1'b1;
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gp_voter.sv
module gp_voter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic         third,
  output logic         ok,
  output logic [W-1:0] val
);
  function automatic logic [W:0] pick(input logic [W-1:0] x, y, z, input logic t);
    if (!t)          return {x == y, x};
    else if (x == y) return {1'b1, x};
    else if (x == z) return {1'b1, x};
    else if (y == z) return {1'b1, y};
    else             return {1'b0, x};
  endfunction

  logic [W:0] res;
  assign res = pick(a, b, c, third);
  assign ok  = res[W];
  assign val = res[W-1:0];
endmodule

// File: rtl/gp_window.sv
module gp_window #(
  parameter int BUDGET = 428
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic over,
  output logic [$clog2(BUDGET+1)-1:0] count
);
  localparam int CW = $clog2(BUDGET + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              count <= '0;
    else if (clr)                            count <= '0;
    else if (run && count != CW'(BUDGET))    count <= count + 1'b1;
  end

  assign over = (count >= CW'(BUDGET));
endmodule

// File: rtl/gp_poller.sv
module gp_poller
  import gp_pkg::*;
#(
  parameter int BITS     = 8,
  parameter int PORTS    = 2,
  parameter int STB_CYC  = 2,
  parameter int HALF_CYC = 4,
  parameter int BUDGET   = 428
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [PORTS-1:0]           pad_data,
  input  logic [PORTS-1:0]           pad_exp,
  output logic [PORTS-1:0]           pad_latch,
  output logic [PORTS-1:0]           pad_clk,
  output logic [PORTS-1:0][BITS-1:0] pad_value,
  output logic [PORTS-1:0]           valid,
  output logic                       done,
  output logic                       overrun
);
  localparam int PW = (PORTS > 1) ? $clog2(PORTS) : 1;
  localparam int CW = $clog2(BUDGET + 1);

  top_state_t      tst;
  logic [PW-1:0]   port_idx;
  logic [1:0]      rd;
  logic            launch;
  logic [BITS-1:0] slot0, slot1;

  logic            eng_latch, eng_sclk, eng_busy, eng_fin, eng_din;
  logic [BITS-1:0] eng_byte;
  logic            v_ok;
  logic [BITS-1:0] v_val, v_b;
  logic            wnd_over;
  logic [CW-1:0]   wnd_count;

  // named internal events for the checker
  logic busy, read_fin, decide, port_done;
  assign busy      = (tst != T_IDLE);
  assign read_fin  = eng_fin;
  assign decide    = (rd == 2'd2) || (rd == 2'd1 && v_ok);
  assign port_done = (tst == T_RUN) && eng_fin && decide;
  assign done      = (tst == T_DONE);

  assign eng_din = pad_data[port_idx] | pad_exp[port_idx];

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign pad_latch[p] = eng_latch && (port_idx == PW'(p));
    assign pad_clk[p]   = eng_sclk  && (port_idx == PW'(p));
  end

  gp_read_engine #(.BITS(BITS), .STB_CYC(STB_CYC), .HALF_CYC(HALF_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(launch), .din(eng_din),
    .latch(eng_latch), .sclk(eng_sclk), .busy(eng_busy), .fin(eng_fin),
    .rd_byte(eng_byte)
  );

  assign v_b = (rd == 2'd1) ? eng_byte : slot1;

  gp_voter #(.W(BITS)) u_vote (
    .a(slot0), .b(v_b), .c(eng_byte), .third(rd == 2'd2),
    .ok(v_ok), .val(v_val)
  );

  gp_window #(.BUDGET(BUDGET)) u_wnd (
    .clk(clk), .rst_n(rst_n), .clr(launch && rd == 2'd0),
    .run(tst == T_RUN), .over(wnd_over), .count(wnd_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tst       <= T_IDLE;
      port_idx  <= '0;
      rd        <= '0;
      launch    <= 1'b0;
      slot0     <= '0;
      slot1     <= '0;
      pad_value <= '0;
      valid     <= '0;
      overrun   <= 1'b0;
    end else begin
      launch <= 1'b0;
      case (tst)
        T_IDLE: if (start) begin
          tst      <= T_RUN;
          port_idx <= '0;
          rd       <= '0;
          launch   <= 1'b1;
          overrun  <= 1'b0;
        end
        T_RUN: if (eng_fin) begin
          if (decide) begin
            if (v_ok) pad_value[port_idx] <= v_val;
            valid[port_idx] <= v_ok;
            if (wnd_over) overrun <= 1'b1;
            if (port_idx == PW'(PORTS - 1)) tst <= T_DONE;
            else begin
              port_idx <= port_idx + 1'b1;
              rd       <= '0;
              launch   <= 1'b1;
            end
          end else begin
            if (rd == 2'd0) slot0 <= eng_byte;
            else            slot1 <= eng_byte;
            rd     <= rd + 1'b1;
            launch <= 1'b1;
          end
        end
        T_DONE: tst <= T_IDLE;
        default: tst <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gp_poller_chk.sv
module gp_poller_chk #(
  parameter int BITS  = 8,
  parameter int PORTS = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       busy,
  input logic                       done,
  input logic                       overrun,
  input logic                       read_fin,
  input logic                       port_done,
  input logic [PORTS-1:0]           pad_latch,
  input logic [PORTS-1:0]           pad_clk,
  input logic [PORTS-1:0][BITS-1:0] pad_value,
  input logic [PORTS-1:0]           valid
);
  p_latch_clk_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_latch & pad_clk) == '0);

  p_one_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pad_latch | pad_clk));

  p_start_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |-> ##2 pad_latch[0]);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(pad_value) && $stable(valid)));

  p_overrun_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !overrun);

  p_fin_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (read_fin || port_done) |-> busy);
endmodule

bind gp_poller gp_poller_chk #(.BITS(BITS), .PORTS(PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .overrun(overrun), .read_fin(read_fin), .port_done(port_done),
  .pad_latch(pad_latch), .pad_clk(pad_clk), .pad_value(pad_value),
  .valid(valid)
);

// File: tb/tb_gp_poller.sv
module tb_pad_model #(
  parameter int STB = 2
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       latch,
  input  logic       sclk,
  input  logic [7:0] v0,
  input  logic [7:0] v1,
  input  logic [7:0] v2,
  input  logic [7:0] ex,
  output logic       dmain,
  output logic       dexp,
  output int         lat_cnt,
  output int         clk_cnt,
  output logic       bad_len
);
  logic [7:0] sr = 8'h00, er = 8'h00;
  logic latch_q = 1'b0, sclk_q = 1'b0;
  int len = 0;
  assign dmain = sr[0];
  assign dexp  = er[0];
  initial begin lat_cnt = 0; clk_cnt = 0; bad_len = 1'b0; end
  always @(posedge clk) begin
    latch_q <= latch;
    sclk_q  <= sclk;
    if (clr) begin lat_cnt <= 0; clk_cnt <= 0; bad_len <= 1'b0; end
    if (latch) len <= len + 1;
    else begin
      if (latch_q && len != STB) bad_len <= 1'b1;
      len <= 0;
    end
    if (latch && !latch_q) begin
      sr <= (lat_cnt == 0) ? v0 : (lat_cnt == 1) ? v1 : v2;
      er <= ex;
      if (!clr) lat_cnt <= lat_cnt + 1;
    end else if (sclk && !sclk_q) begin
      sr <= {1'b1, sr[7:1]};
      er <= {1'b0, er[7:1]};
      if (!clr) clk_cnt <= clk_cnt + 1;
    end
  end
endmodule

module tb_gp_poller;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, start_s = 1'b0, clr = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] sa[NP], sb[NP], sc[NP], ex[NP];
  logic [NP-1:0] pdat, pexp, plat, pclk, valid, pdat_s, pexp_s, plat_s, pclk_s, valid_s;
  logic [NP-1:0][7:0] pval, pval_s;
  logic done, overrun, done_s, overrun_s;
  int lat_cnt[NP], clk_cnt[NP], lat_s[NP], clk_s[NP];
  logic bad_len[NP], bad_s[NP];

  gp_poller dut (.clk(clk), .rst_n(rst_n), .start(start), .pad_data(pdat), .pad_exp(pexp),
    .pad_latch(plat), .pad_clk(pclk), .pad_value(pval), .valid(valid), .done(done),
    .overrun(overrun));

  gp_poller #(.HALF_CYC(30)) dut_slow (.clk(clk), .rst_n(rst_n), .start(start_s),
    .pad_data(pdat_s), .pad_exp(pexp_s), .pad_latch(plat_s), .pad_clk(pclk_s),
    .pad_value(pval_s), .valid(valid_s), .done(done_s), .overrun(overrun_s));

  for (genvar p = 0; p < NP; p++) begin : g_pad
    tb_pad_model u_m (.clk(clk), .clr(clr), .latch(plat[p]), .sclk(pclk[p]),
      .v0(sa[p]), .v1(sb[p]), .v2(sc[p]), .ex(ex[p]), .dmain(pdat[p]), .dexp(pexp[p]),
      .lat_cnt(lat_cnt[p]), .clk_cnt(clk_cnt[p]), .bad_len(bad_len[p]));
    tb_pad_model u_s (.clk(clk), .clr(clr), .latch(plat_s[p]), .sclk(pclk_s[p]),
      .v0(8'h5A), .v1(8'h5A), .v2(8'h5A), .ex(8'h00), .dmain(pdat_s[p]), .dexp(pexp_s[p]),
      .lat_cnt(lat_s[p]), .clk_cnt(clk_s[p]), .bad_len(bad_s[p]));
  end

  int n_chk = 0, n_fail = 0, cyc = 0, done_cnt = 0, last0 = 0, first1 = 0;
  logic [7:0] prev[NP];
  bit finished = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr) begin done_cnt <= 0; last0 <= 0; first1 <= 0; end
    else begin
      if (done) done_cnt <= done_cnt + 1;
      if (pclk[0]) last0 <= cyc;
      if ((plat[1] || pclk[1]) && first1 == 0) first1 <= cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic exp_vote(input logic [7:0] a, b, c, pv,
                          output logic [7:0] v, output bit ok, output int n);
    if (a == b)      begin v = a;  ok = 1; n = 2; end
    else if (c == a) begin v = a;  ok = 1; n = 3; end
    else if (c == b) begin v = b;  ok = 1; n = 3; end
    else             begin v = pv; ok = 0; n = 3; end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic frame(input bit extra_start);
    logic [7:0] v; bit ok; int n; int t;
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0; start = 1;
    @(negedge clk) start = 0;
    if (extra_start) begin
      repeat (20) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
    end
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(t < 5000, "R8 done timeout", t, 0);
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R8 done width", done_cnt, 1);
    chk(overrun == 0, "R9 fast overrun", overrun, 0);
    chk(first1 > last0, "R7 port order", first1, last0);
    for (int p = 0; p < NP; p++) begin
      exp_vote(sa[p] | ex[p], sb[p] | ex[p], sc[p] | ex[p], prev[p], v, ok, n);
      chk(pval[p] == v, ok ? "R4/R5 value (R3 order)" : "R6 held value", pval[p], v);
      chk(valid[p] == ok, ok ? "R5 valid" : "R6 valid low", valid[p], ok);
      chk(lat_cnt[p] == n, n == 2 ? "R4 read count" : "R5 read count (R10)", lat_cnt[p], n);
      chk(clk_cnt[p] == 8 * n && !bad_len[p], "R2 latch/clock shape", clk_cnt[p], 8 * n);
      prev[p] = v;
    end
  endtask

  task automatic set_port(input int p, input logic [7:0] a, b, c, e);
    sa[p] = a; sb[p] = b; sc[p] = c; ex[p] = e;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7741));
    for (int p = 0; p < NP; p++) begin set_port(p, 0, 0, 0, 0); prev[p] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pval == '0 && valid == '0, "R1 reset outputs", pval, 0);
    chk(plat == '0 && pclk == '0 && !done && !overrun, "R1 reset lines", {plat, pclk}, 0);

    // R4: agreeing first pair
    set_port(0, 8'h3C, 8'h3C, 8'hFF, 0); set_port(1, 8'hA5, 8'hA5, 8'h00, 0);
    frame(0);
    // R3: LSB-first order and OR with expansion line
    set_port(0, 8'h01, 8'h01, 8'h01, 8'h00); set_port(1, 8'h80, 8'h80, 8'h80, 8'h06);
    frame(0);
    // R5: third read matches first / matches second
    set_port(0, 8'h11, 8'h13, 8'h11, 0); set_port(1, 8'h40, 8'h41, 8'h41, 0);
    frame(0);
    // R6: no agreement keeps the previous byte
    set_port(0, 8'h01, 8'h02, 8'h04, 0); set_port(1, 8'hF0, 8'h0F, 8'hFF, 0);
    frame(0);
    // R10: start pulse during a frame
    set_port(0, 8'h77, 8'h77, 8'h00, 0); set_port(1, 8'h21, 8'h22, 8'h21, 0);
    frame(1);

    for (int k = 0; k < 40; k++) begin
      for (int p = 0; p < NP; p++) begin
        logic [7:0] a, b, c;
        int mode;
        a = 8'($urandom); b = 8'($urandom); c = 8'($urandom); mode = $urandom % 4;
        if (mode == 0) begin b = a; c = a; end
        else if (mode == 1) b = a;
        else if (mode == 2) c = ($urandom % 2) ? a : b;
        set_port(p, a, b, c, ($urandom % 4 == 0) ? 8'($urandom) : 8'h00);
      end
      frame(0);
    end

    // R9: slow shift clock exceeds the cycle budget
    @(negedge clk) start_s = 1;
    @(negedge clk) start_s = 0;
    begin
      int t = 0;
      while (!done_s && t < 20000) begin @(negedge clk); t++; end
    end
    chk(overrun_s == 1, "R9 slow overrun", overrun_s, 1);
    chk(pval_s[0] == 8'h5A && pval_s[1] == 8'h5A && valid_s == 2'b11, "R4 slow value",
        pval_s, 16'h5A5A);
    finish_run();
  end
endmodule